// File: doc/BRIEF.md
# Scan Response Comparator with Sticky Verdict

This block terminates a set of parallel scan chains inside the chip. During a test session the tester shifts expected response bits into the chip next to the scan stimulus. Each shift cycle, the block compares the bit coming out of every chain against its expected bit. Raw scan contents therefore never reach a pin.

Any compare failure sets a single sticky error flag. The flag is held until a synchronous clear or the asynchronous reset. When the tester pulses the done input, the block registers a one-bit pass verdict and raises a verdict-valid flag. Between done pulses the exported verdict does not move, so the ports reveal nothing about individual scan bits.

A per-chain compare enable lets the tester skip don't-care response bits. Capture cycles, when scan enable is low, are never compared.

Top module: `scan_resp_cmp`

## Requirements
- R1: After reset, pass_o is 0, done_o is 0 and the sticky error flag is clear, so a done pulse with no compare failures gives pass_o = 1.
- R2: Each cycle, a mismatch is counted for chain k when scan_en_i = 1, cmp_en_i[k] = 1 and scan_out_i[k] differs from exp_i[k].
- R3: A mismatch on any one chain sets the sticky error flag.
- R4: Once set, the error flag stays set through any number of later matching cycles until clr_i or reset.
- R5: When clr_i = 1, the flag is 0 after that edge, and a mismatch in the same cycle is discarded.
- R6: On a cycle with done_i = 1, pass_o takes the value 1 only if no mismatch occurred since the last clear, counting the done cycle itself, and 0 otherwise. done_o becomes 1 at the same edge.
- R7: pass_o changes only at an edge where done_i = 1. done_o falls only on a clr_i cycle without done_i.
- R8: When scan_en_i = 0 (capture), differing bits never set the flag.
- R9: A chain whose cmp_en_i bit is 0 never sets the flag, whatever its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_en_i | input | 1 | High during shift cycles, low during capture |
| clr_i | input | 1 | Synchronous clear of the error flag and of done_o |
| cmp_en_i | input | NUM_CHAINS | Per-chain compare enable (0 = don't care) |
| scan_out_i | input | NUM_CHAINS | Response bits leaving the chains |
| exp_i | input | NUM_CHAINS | Expected response bits from the tester |
| done_i | input | 1 | Strobe that latches the verdict |
| pass_o | output | 1 | Registered verdict, 1 = no mismatch |
| done_o | output | 1 | Verdict valid |

## Verification
The error flag is visible only through the verdict. A wrong flag state therefore shows up as a wrong pass_o one edge after the next done pulse, and at no earlier point. The bench pulses done_i often, both in directed sequences and at random, so that a flag that sets or clears wrongly is seen within a few cycles of the cause. The bench also checks pass_o and done_o on every cycle, so a verdict that moves outside a done pulse is caught on the edge where it moves.

// File: rtl/scmp_pkg.sv
package scmp_pkg;
  typedef struct packed {
    logic pass;
    logic valid;
  } verdict_t;
endpackage

// File: rtl/cmp_lane.sv
module cmp_lane (
  input  logic shift_i,
  input  logic en_i,
  input  logic act_i,
  input  logic exp_i,
  output logic mism_o
);
  assign mism_o = shift_i & en_i & (act_i ^ exp_i);
endmodule

// File: rtl/err_sticky.sv
module err_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  output logic err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= 1'b0;
    else if (clr_i) err_q <= 1'b0;   // clear beats a same-cycle set
    else if (set_i) err_q <= 1'b1;
  end

  assign err_o = err_q;

  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !err_q); // R5
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr_i) |=> err_q); // R4
  AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> err_q); // R3
endmodule

// File: rtl/verdict_reg.sv
module verdict_reg
  import scmp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     done_i,
  input  logic     clr_i,
  input  logic     fail_i,
  output verdict_t verdict_o
);
  verdict_t v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
    end else if (done_i) begin
      v_q.pass  <= ~fail_i;
      v_q.valid <= 1'b1;
    end else if (clr_i) begin
      v_q.valid <= 1'b0;
    end
  end

  assign verdict_o = v_q;

  AST_PASS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(v_q.pass)); // R7
  AST_DONE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> v_q.valid); // R6
  AST_FAIL_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && fail_i) |=> !v_q.pass); // R6
endmodule

// File: rtl/scan_resp_cmp.sv
module scan_resp_cmp
  import scmp_pkg::*;
#(
  parameter int unsigned NUM_CHAINS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scan_en_i,
  input  logic                  clr_i,
  input  logic [NUM_CHAINS-1:0] cmp_en_i,
  input  logic [NUM_CHAINS-1:0] scan_out_i,
  input  logic [NUM_CHAINS-1:0] exp_i,
  input  logic                  done_i,
  output logic                  pass_o,
  output logic                  done_o
);
  localparam int unsigned LaneW = NUM_CHAINS;

  logic [LaneW-1:0] lane_mism;
  logic             any_mism;
  logic             err_q;
  logic             fail_now;
  verdict_t         verdict;

  for (genvar k = 0; k < LaneW; k++) begin : g_lane
    cmp_lane i_lane (
      .shift_i (scan_en_i),
      .en_i    (cmp_en_i[k]),
      .act_i   (scan_out_i[k]),
      .exp_i   (exp_i[k]),
      .mism_o  (lane_mism[k])
    );
  end

  assign any_mism = |lane_mism;

  err_sticky i_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .set_i  (any_mism),
    .err_o  (err_q)
  );

  // done-cycle mismatch counts toward the verdict
  assign fail_now = err_q | any_mism;

  verdict_reg i_verdict (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done_i),
    .clr_i     (clr_i),
    .fail_i    (fail_now),
    .verdict_o (verdict)
  );

  assign pass_o = verdict.pass;
  assign done_o = verdict.valid;

  AST_CAPTURE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_en_i && !err_q) |=> !err_q); // R8
  AST_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmp_en_i == '0) && !err_q) |=> !err_q); // R9
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_i) |=> done_o); // R7
endmodule

// File: tb/test_scan_resp_cmp.sv
module test_scan_resp_cmp;
  localparam int N = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         scan_en_i = 1'b0;
  logic         clr_i = 1'b0;
  logic [N-1:0] cmp_en_i = '0;
  logic [N-1:0] scan_out_i = '0;
  logic [N-1:0] exp_i = '0;
  logic         done_i = 1'b0;
  logic         pass_o;
  logic         done_o;

  int total = 0;
  int bad = 0;
  bit m_err = 1'b0, m_pass = 1'b0, m_done = 1'b0;

  always #2 clk_i = ~clk_i;

  scan_resp_cmp #(.NUM_CHAINS(N)) i_scan_resp_cmp (
    .clk_i, .rst_ni, .scan_en_i, .clr_i, .cmp_en_i,
    .scan_out_i, .exp_i, .done_i, .pass_o, .done_o
  );

  function automatic bit mism(bit se, logic [N-1:0] en, logic [N-1:0] so, logic [N-1:0] ex);
    return se && ((en & (so ^ ex)) != '0);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one cycle, update model, check outputs just after the edge
  task automatic step(bit se, logic [N-1:0] en, logic [N-1:0] so, logic [N-1:0] ex,
                      bit clr, bit dn, string req);
    bit mm;
    @(negedge clk_i);
    scan_en_i = se; cmp_en_i = en; scan_out_i = so; exp_i = ex;
    clr_i = clr; done_i = dn;
    mm = mism(se, en, so, ex);
    if (dn) begin m_pass = !(m_err || mm); m_done = 1'b1; end
    else if (clr) m_done = 1'b0;
    m_err = clr ? 1'b0 : (m_err || mm);
    @(posedge clk_i); #1;
    check(pass_o == m_pass, req, "pass_o", pass_o, m_pass);
    check(done_o == m_done, req, "done_o", done_o, m_done);
  endtask

  task automatic idle(string req);
    step(1'b0, '0, '0, '0, 1'b0, 1'b0, req);
  endtask

  initial begin
    #3000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    check(pass_o == 1'b0 && done_o == 1'b0, "R1", "reset outputs", {pass_o, done_o}, 0);
    #9 rst_ni = 1'b1;
    // R1: fresh session passes
    step(1'b1, '1, 4'hA, 4'hA, 1'b0, 1'b1, "R1");
    // R8: capture cycle differences ignored
    step(1'b0, '1, 4'hF, 4'h0, 1'b0, 1'b0, "R8");
    step(1'b0, '1, 4'h0, 4'hF, 1'b0, 1'b1, "R8");
    check(pass_o == 1'b1, "R8", "pass after capture diffs", pass_o, 1);
    // R9: masked chain differing
    step(1'b1, 4'b1101, 4'b0010, 4'b0000, 1'b0, 1'b1, "R9");
    check(pass_o == 1'b1, "R9", "pass with masked diff", pass_o, 1);
    // R3: single chain mismatch, chain 3
    step(1'b1, '1, 4'b1000, 4'b0000, 1'b0, 1'b0, "R3");
    for (int i = 0; i < 20; i++) step(1'b1, '1, 4'h5, 4'h5, 1'b0, 1'b0, "R4");
    // R7: no done yet, pass still 1
    check(pass_o == 1'b1, "R7", "pass held until done", pass_o, 1);
    step(1'b1, '1, 4'h5, 4'h5, 1'b0, 1'b1, "R4");
    check(pass_o == 1'b0, "R4", "sticky fail after matches", pass_o, 0);
    // R5: clear with simultaneous mismatch
    step(1'b1, '1, 4'hF, 4'h0, 1'b1, 1'b0, "R5");
    check(done_o == 1'b0, "R7", "done_o cleared by clr", done_o, 0);
    step(1'b1, '1, 4'h3, 4'h3, 1'b0, 1'b1, "R5");
    check(pass_o == 1'b1, "R5", "clear wins over mismatch", pass_o, 1);
    // R6: mismatch in the done cycle itself
    step(1'b1, 4'b0001, 4'b0001, 4'b0000, 1'b0, 1'b1, "R6");
    check(pass_o == 1'b0, "R6", "done-cycle mismatch", pass_o, 0);
    // R2: random traffic
    for (int i = 0; i < 3000; i++) begin
      bit se, cl, dn;
      logic [N-1:0] en, so, ex;
      se = ($urandom % 4) != 0;
      en = N'($urandom);
      so = N'($urandom);
      ex = (($urandom % 8) == 0) ? N'($urandom) : so;
      cl = ($urandom % 40) == 0;
      dn = ($urandom % 12) == 0;
      step(se, en, so, ex, cl, dn, "R2");
    end
    idle("R7");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule